// File: doc/BRIEF.md
# Address-Space Command Sequencer

This block runs the register-level protocol that maintains one translation address space: it takes a flush request with a precomputed lock word and turns it into an ordered series of writes and status polls on a simple host-side register port. Every write to the address-space command register comes only after a status read that shows the space idle. Each poll is bounded, so a hung unit ends the operation with an error instead of stalling it.

Three flush recipes exist. The plain recipe locks the region and issues the flush command. The workaround recipe applies only to a memory flush while the L2 is powered. It cleans and invalidates the load/store cache, waits for the shader power transitions to settle, and then issues a page-table-only flush. The cache-controller recipe locks the region, flushes caches through the global cache command, and then unlocks the region. Requests use a valid/ready handshake: `req_ready` is high only when the sequencer is idle, and a request is taken on a cycle where both are high. On the register port the sequencer holds a request stable while `port_req_ready` is low and keeps one access outstanding. Every accepted access, read or write, returns one `port_rsp_valid` pulse.

Top module: `as_cmd_seq`

## Requirements
- R1: Before every write to the command register (address 1), the status register (address 0) is read until bit 0 reads 0. If POLL_LIMIT reads in a row show bit 0 set, the operation ends with error code 2 and the pending write is not made. Every status wait inside a sequence is bounded by the same limit.
- R2: Operation code 0 means page-table flush and 1 means memory flush. Codes 2 and 3 are refused: `done` rises on the cycle after acceptance with error 1, and no register access is made.
- R3: The plain recipe runs in this order: write lock word bits [DW-1:0] to address 2, write bits [2DW-1:DW] to address 3, status wait, LOCK (code 2), status wait, flush command (4 for page-table, 5 for memory), and a final status wait. A clean run ends with error 0.
- R4: The workaround recipe is selected when `wa_en` is high, the operation is a memory flush, and `l2_on` is high. After LOCK it runs a status wait, writes code 1 to the cache command register (address 4), and polls the cache status register (address 5) bit 0 under the same limit. It then runs the power drain and issues command 4 instead of 5. A timed-out cache poll ends the operation with error 2 before the flush command.
- R5: The power drain reads address 6 and then address 7 and passes when both read zero. Between failed attempts it waits at least TICK_DIV clock cycles. After PWR_LIMIT failed attempts the operation ends with error 3 and no flush command is written.
- R6: When `l2_on` is low, or the operation is a page-table flush, the workaround is skipped: the plain recipe runs and no cache command is written.
- R7: When `gpu_path` is high, which takes priority over `wa_en`, the sequence is: lock halves, status wait, LOCK, status wait, cache command (2 for page-table, 3 for memory), cache status poll, status wait, UNLOCK (code 3), status wait. UNLOCK is attempted even when the cache poll timed out, and the first error is the one reported.
- R8: `done` is high for exactly one cycle per accepted request and `err` is valid in that cycle. Requests are refused while busy. A register-port request holds its address, data and direction stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Flush request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation code |
| req_lock | input | 2*DW | Precomputed lock word |
| wa_en | input | 1 | Enable the workaround recipe |
| gpu_path | input | 1 | Use the cache-controller recipe |
| l2_on | input | 1 | L2 cache currently powered |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 bad op, 2 busy timeout, 3 power timeout |
| port_req_valid | output | 1 | Register access request |
| port_req_ready | input | 1 | Register port accepts the request |
| port_we | output | 1 | 1 write, 0 read |
| port_addr | output | 3 | Register address |
| port_wdata | output | DW | Write data |
| port_rsp_valid | input | 1 | Response for the outstanding access |
| port_rsp_rdata | input | DW | Read data |

## Verification
The hardest situation to reach is a cache-poll timeout in the cache-controller recipe. There the error has to be latched while the sequence still goes on to a clean status wait and an UNLOCK. The bench's register model keeps the cache status busy for more reads than the limit allows, while the address-space status clears quickly, and then checks that both LOCK and UNLOCK were written and that error 2 was reported. The power-drain retry spacing is measured in the same model as the cycle distance between a failing high-word read and the next low-word read.

// File: rtl/asq_pkg.sv
package asq_pkg;
  localparam int AW   = 3;
  localparam int PLEN = 16;
  localparam int SW   = $clog2(PLEN);

  localparam logic [AW-1:0] A_STATUS  = 3'd0;
  localparam logic [AW-1:0] A_COMMAND = 3'd1;
  localparam logic [AW-1:0] A_LOCK_LO = 3'd2;
  localparam logic [AW-1:0] A_LOCK_HI = 3'd3;
  localparam logic [AW-1:0] A_CCMD    = 3'd4;
  localparam logic [AW-1:0] A_CSTAT   = 3'd5;
  localparam logic [AW-1:0] A_PWR_LO  = 3'd6;
  localparam logic [AW-1:0] A_PWR_HI  = 3'd7;

  localparam logic [7:0] C_LOCK   = 8'd2;
  localparam logic [7:0] C_UNLOCK = 8'd3;
  localparam logic [7:0] C_FL_PT  = 8'd4;
  localparam logic [7:0] C_FL_MEM = 8'd5;
  localparam logic [7:0] G_LSC    = 8'd1;
  localparam logic [7:0] G_L2     = 8'd2;
  localparam logic [7:0] G_L2_LSC = 8'd3;

  localparam logic [1:0] E_NONE  = 2'd0;
  localparam logic [1:0] E_BADOP = 2'd1;
  localparam logic [1:0] E_BUSY  = 2'd2;
  localparam logic [1:0] E_PWR   = 2'd3;

  typedef enum logic [1:0] {K_END, K_WR, K_POLL, K_PWR} kind_e;
  typedef enum logic [1:0] {S_CODE, S_LO, S_HI} src_e;

  typedef struct packed {
    kind_e         kind;
    logic [AW-1:0] addr;
    src_e          src;
    logic [7:0]    code;
    logic          keep;
  } uop_t;

  function automatic uop_t mk_wr(logic [AW-1:0] a, src_e s, logic [7:0] c);
    return '{kind: K_WR, addr: a, src: s, code: c, keep: 1'b0};
  endfunction

  function automatic uop_t mk_poll(logic [AW-1:0] a, logic k);
    return '{kind: K_POLL, addr: a, src: S_CODE, code: 8'd0, keep: k};
  endfunction

  function automatic uop_t mk_pwr();
    return '{kind: K_PWR, addr: A_PWR_LO, src: S_CODE, code: 8'd0, keep: 1'b0};
  endfunction

  function automatic uop_t mk_end();
    return '{kind: K_END, addr: '0, src: S_CODE, code: 8'd0, keep: 1'b0};
  endfunction
endpackage

// File: rtl/asq_tick.sv
module asq_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr || tick)   cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && DIV > 1) |=> !tick); // R5
endmodule

// File: rtl/asq_plan.sv
module asq_plan import asq_pkg::*; (
  input  logic          mem,
  input  logic          wa,
  input  logic          gpu,
  input  logic [SW-1:0] step,
  output uop_t          uop
);
  uop_t prog [PLEN];

  always_comb begin
    for (int i = 0; i < PLEN; i++) prog[i] = mk_end();
    prog[0] = mk_wr(A_LOCK_LO, S_LO, 8'd0);
    prog[1] = mk_wr(A_LOCK_HI, S_HI, 8'd0);
    prog[2] = mk_poll(A_STATUS, 1'b0);
    prog[3] = mk_wr(A_COMMAND, S_CODE, C_LOCK);
    prog[4] = mk_poll(A_STATUS, 1'b0);
    if (gpu) begin
      prog[5] = mk_wr(A_CCMD, S_CODE, mem ? G_L2_LSC : G_L2);
      prog[6] = mk_poll(A_CSTAT, 1'b1);
      prog[7] = mk_poll(A_STATUS, 1'b0);
      prog[8] = mk_wr(A_COMMAND, S_CODE, C_UNLOCK);
      prog[9] = mk_poll(A_STATUS, 1'b0);
    end else if (wa) begin
      prog[5]  = mk_wr(A_CCMD, S_CODE, G_LSC);
      prog[6]  = mk_poll(A_CSTAT, 1'b0);
      prog[7]  = mk_pwr();
      prog[8]  = mk_poll(A_STATUS, 1'b0);
      prog[9]  = mk_wr(A_COMMAND, S_CODE, C_FL_PT);
      prog[10] = mk_poll(A_STATUS, 1'b0);
    end else begin
      prog[5] = mk_wr(A_COMMAND, S_CODE, mem ? C_FL_MEM : C_FL_PT);
      prog[6] = mk_poll(A_STATUS, 1'b0);
    end
  end

  assign uop = prog[step];
endmodule

// File: rtl/as_cmd_seq.sv
module as_cmd_seq import asq_pkg::*; #(
  parameter int DW         = 32,
  parameter int POLL_LIMIT = 64,
  parameter int PWR_LIMIT  = 1000,
  parameter int TICK_DIV   = 250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [2*DW-1:0] req_lock,
  input  logic            wa_en,
  input  logic            gpu_path,
  input  logic            l2_on,
  output logic            done,
  output logic [1:0]      err,
  output logic            port_req_valid,
  input  logic            port_req_ready,
  output logic            port_we,
  output logic [2:0]      port_addr,
  output logic [DW-1:0]   port_wdata,
  input  logic            port_rsp_valid,
  input  logic [DW-1:0]   port_rsp_rdata
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam int WCW = $clog2(PWR_LIMIT + 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_LIMIT - 1);
  localparam logic [WCW-1:0] PWR_LAST  = WCW'(PWR_LIMIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_DONE} st_e;

  st_e             st_q;
  logic [SW-1:0]   step_q;
  logic [2*DW-1:0] lock_q;
  logic            mem_q, wa_q, gpu_q;
  logic [1:0]      err_q;
  logic [PCW-1:0]  poll_q;
  logic [WCW-1:0]  pwr_q;
  logic            half_q, lo_nz_q;
  logic            stat_ok_q;
  logic            tick;
  uop_t            uop;

  asq_plan u_plan (.mem(mem_q), .wa(wa_q), .gpu(gpu_q), .step(step_q), .uop(uop));

  asq_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n),
    .clr(st_q != S_GAP), .tick(tick));

  assign req_ready      = (st_q == S_IDLE);
  assign done           = (st_q == S_DONE);
  assign err            = err_q;
  assign port_req_valid = (st_q == S_ISSUE) && (uop.kind != K_END);
  assign port_we        = (uop.kind == K_WR);
  assign port_addr      = (uop.kind == K_PWR) ? (half_q ? A_PWR_HI : A_PWR_LO) : uop.addr;

  always_comb begin
    case (uop.src)
      S_LO:    port_wdata = lock_q[DW-1:0];
      S_HI:    port_wdata = lock_q[2*DW-1:DW];
      default: port_wdata = DW'(uop.code);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; step_q <= '0; lock_q <= '0;
      mem_q <= 1'b0; wa_q <= 1'b0; gpu_q <= 1'b0; err_q <= E_NONE;
      poll_q <= '0; pwr_q <= '0; half_q <= 1'b0; lo_nz_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          lock_q <= req_lock;
          mem_q  <= (req_op == 2'd1);
          wa_q   <= wa_en && l2_on && (req_op == 2'd1);
          gpu_q  <= gpu_path;
          step_q <= '0; poll_q <= '0; pwr_q <= '0; half_q <= 1'b0;
          if (req_op[1]) begin err_q <= E_BADOP; st_q <= S_DONE; end
          else           begin err_q <= E_NONE;  st_q <= S_ISSUE; end
        end
        S_ISSUE: begin
          if (uop.kind == K_END)    st_q <= S_DONE;
          else if (port_req_ready)  st_q <= S_WAIT;
        end
        S_WAIT: if (port_rsp_valid) begin
          case (uop.kind)
            K_POLL: begin
              if (!port_rsp_rdata[0]) begin
                step_q <= step_q + 1'b1; poll_q <= '0; st_q <= S_ISSUE;
              end else if (poll_q == POLL_LAST) begin
                if (err_q == E_NONE) err_q <= E_BUSY;
                poll_q <= '0;
                if (uop.keep) begin step_q <= step_q + 1'b1; st_q <= S_ISSUE; end
                else          st_q <= S_DONE;
              end else begin
                poll_q <= poll_q + 1'b1; st_q <= S_ISSUE;
              end
            end
            K_PWR: begin
              if (!half_q) begin
                lo_nz_q <= |port_rsp_rdata; half_q <= 1'b1; st_q <= S_ISSUE;
              end else if (!lo_nz_q && port_rsp_rdata == '0) begin
                half_q <= 1'b0; step_q <= step_q + 1'b1; st_q <= S_ISSUE;
              end else if (pwr_q == PWR_LAST) begin
                if (err_q == E_NONE) err_q <= E_PWR;
                st_q <= S_DONE;
              end else begin
                pwr_q <= pwr_q + 1'b1; half_q <= 1'b0; st_q <= S_GAP;
              end
            end
            default: begin step_q <= step_q + 1'b1; st_q <= S_ISSUE; end
          endcase
        end
        S_GAP:   if (tick) st_q <= S_ISSUE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // Observer: last status read was clean and no command write has used it yet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_ok_q <= 1'b0;
    else if (port_req_valid && port_req_ready && port_we && port_addr == A_COMMAND)
      stat_ok_q <= 1'b0;
    else if (st_q == S_WAIT && port_rsp_valid && !port_we && port_addr == A_STATUS)
      stat_ok_q <= !port_rsp_rdata[0];
  end

  AST_CMD_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req_valid && port_req_ready && port_we && port_addr == A_COMMAND) |-> stat_ok_q); // R1
  AST_BADOP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1]) |=> (done && err == E_BADOP && !port_req_valid)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req_valid && !port_req_ready) |=>
      (port_req_valid && $stable(port_addr) && $stable(port_wdata) && $stable(port_we))); // R8
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    port_req_valid |-> !req_ready); // R8
endmodule

// File: tb/as_cmd_seq_tb.sv
module as_cmd_seq_tb;
  localparam int DW = 32, PL = 6, WL = 5, TD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready, wa_en = 1'b0, gpu_path = 1'b0, l2_on = 1'b0;
  logic [1:0] req_op = 2'd0, err;
  logic [63:0] req_lock = '0;
  logic done, preq_v, preq_rdy, pwe, rsp_v;
  logic [2:0] paddr;
  logic [DW-1:0] pwdata, rdata;

  as_cmd_seq #(.DW(DW), .POLL_LIMIT(PL), .PWR_LIMIT(WL), .TICK_DIV(TD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_lock(req_lock), .wa_en(wa_en), .gpu_path(gpu_path),
    .l2_on(l2_on), .done(done), .err(err), .port_req_valid(preq_v),
    .port_req_ready(preq_rdy), .port_we(pwe), .port_addr(paddr),
    .port_wdata(pwdata), .port_rsp_valid(rsp_v), .port_rsp_rdata(rdata));

  // register model configuration, driven only by the initial block
  logic load = 1'b0;
  int cfg_as_init = 0, cfg_as_lat = 0, cfg_gpu_lat = 0, cfg_pwr = 0;

  // register model state
  int as_busy, gpu_busy, pwr_busy, nacc, nwr, ncmd, cyc, last_hi, min_gap;
  logic [31:0] cmds;
  logic [7:0] gpu_seen;
  logic [2:0] w0a, w1a;
  logic [DW-1:0] w0d, w1d;

  initial cyc = 0;
  assign preq_rdy = (cyc % 4) != 3;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_v <= 1'b0;
    if (load) begin
      as_busy <= cfg_as_init; gpu_busy <= 0; pwr_busy <= cfg_pwr;
      nacc <= 0; nwr <= 0; ncmd <= 0; cmds <= '0; gpu_seen <= '0;
      last_hi <= -1; min_gap <= 1000000; w0a <= '0; w1a <= '0; w0d <= '0; w1d <= '0;
    end else if (preq_v && preq_rdy) begin
      nacc <= nacc + 1;
      rsp_v <= 1'b1;
      rdata <= '0;
      if (pwe) begin
        nwr <= nwr + 1;
        if (nwr == 0) begin w0a <= paddr; w0d <= pwdata; end
        if (nwr == 1) begin w1a <= paddr; w1d <= pwdata; end
        if (paddr == 3'd1) begin
          if (ncmd < 4) cmds[ncmd*8 +: 8] <= pwdata[7:0];
          ncmd <= ncmd + 1;
          as_busy <= cfg_as_lat;
        end
        if (paddr == 3'd4) begin gpu_seen <= pwdata[7:0]; gpu_busy <= cfg_gpu_lat; end
      end else begin
        case (paddr)
          3'd0: begin rdata <= DW'(as_busy != 0); if (as_busy != 0) as_busy <= as_busy - 1; end
          3'd5: begin rdata <= DW'(gpu_busy != 0); if (gpu_busy != 0) gpu_busy <= gpu_busy - 1; end
          3'd6: if (last_hi >= 0 && (cyc - last_hi) < min_gap) min_gap <= cyc - last_hi;
          3'd7: begin
            rdata <= (pwr_busy != 0) ? 32'h0000_0100 : 32'h0;
            if (pwr_busy != 0) pwr_busy <= pwr_busy - 1;
            last_hi <= cyc;
          end
          default: ;
        endcase
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] op; logic wa; logic gp; logic l2;
    logic [4:0] as_init; logic [4:0] as_lat; logic [4:0] gpu_lat; logic [4:0] pwr;
    logic [1:0] err; logic [2:0] ncmd; logic [31:0] cmds; logic [7:0] gpu;
  } vec_t;

  // op wa gp l2 as_init as_lat gpu_lat pwr | err ncmd cmds gpu
  localparam vec_t VT [14] = '{
    '{2'd0,1'b0,1'b0,1'b0, 5'd0, 5'd2, 5'd0, 5'd0,  2'd0,3'd2,32'h0402,8'd0}, // R3 PT
    '{2'd1,1'b0,1'b0,1'b0, 5'd0, 5'd2, 5'd0, 5'd0,  2'd0,3'd2,32'h0502,8'd0}, // R3 MEM
    '{2'd1,1'b1,1'b0,1'b0, 5'd0, 5'd2, 5'd0, 5'd0,  2'd0,3'd2,32'h0502,8'd0}, // R6 L2 off
    '{2'd1,1'b1,1'b0,1'b1, 5'd0, 5'd2, 5'd2, 5'd2,  2'd0,3'd2,32'h0402,8'd1}, // R4 workaround
    '{2'd0,1'b1,1'b0,1'b1, 5'd0, 5'd2, 5'd2, 5'd0,  2'd0,3'd2,32'h0402,8'd0}, // R6 PT skips
    '{2'd1,1'b1,1'b0,1'b1, 5'd0, 5'd2, 5'd2, 5'd10, 2'd3,3'd1,32'h0002,8'd1}, // R5 pwr timeout
    '{2'd0,1'b0,1'b0,1'b0, 5'd10,5'd2, 5'd0, 5'd0,  2'd2,3'd0,32'h0000,8'd0}, // R1 before LOCK
    '{2'd1,1'b0,1'b0,1'b0, 5'd0, 5'd10,5'd0, 5'd0,  2'd2,3'd1,32'h0002,8'd0}, // R1 before flush
    '{2'd0,1'b0,1'b1,1'b0, 5'd0, 5'd2, 5'd2, 5'd0,  2'd0,3'd2,32'h0302,8'd2}, // R7 PT
    '{2'd1,1'b1,1'b1,1'b1, 5'd0, 5'd2, 5'd2, 5'd0,  2'd0,3'd2,32'h0302,8'd3}, // R7 MEM
    '{2'd1,1'b0,1'b1,1'b0, 5'd0, 5'd2, 5'd10,5'd0,  2'd2,3'd2,32'h0302,8'd3}, // R7 unlock after fail
    '{2'd1,1'b1,1'b0,1'b1, 5'd0, 5'd2, 5'd10,5'd0,  2'd2,3'd1,32'h0002,8'd1}, // R4 cache timeout
    '{2'd2,1'b0,1'b0,1'b0, 5'd0, 5'd2, 5'd0, 5'd0,  2'd1,3'd0,32'h0000,8'd0}, // R2
    '{2'd3,1'b1,1'b1,1'b1, 5'd0, 5'd2, 5'd0, 5'd0,  2'd1,3'd0,32'h0000,8'd0}  // R2
  };

  int got_err, done_cnt, wd = 0;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input vec_t v, input logic [63:0] lw, input logic intrude);
    @(negedge clk);
    cfg_as_init = int'(v.as_init); cfg_as_lat = int'(v.as_lat);
    cfg_gpu_lat = int'(v.gpu_lat); cfg_pwr = int'(v.pwr);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    req_valid = 1'b1; req_op = v.op; req_lock = lw;
    wa_en = v.wa; gpu_path = v.gp; l2_on = v.l2;
    @(negedge clk);
    req_valid = 1'b0;
    done_cnt = 0; got_err = -1;
    if (intrude) begin
      chk("R8 ready low while busy", int'(req_ready), 0);
      req_valid = 1'b1; req_op = 2'd2;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    for (int k = 0; k < 3000; k++) begin
      if (done) begin done_cnt++; got_err = int'(err); end
      if (done_cnt != 0 && !done) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset ready", int'(req_ready), 1);
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset port idle", int'(preq_v), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      logic [63:0] lw;
      lw = {32'hA500_0000 | 32'(i), 32'h0000_5A00 | 32'(i)};
      run_op(VT[i], lw, 1'b0);
      chk($sformatf("R8 vec %0d done count", i), done_cnt, 1);
      chk($sformatf("R1 R5 R7 vec %0d err", i), got_err, int'(VT[i].err));
      chk($sformatf("R3 R4 R7 vec %0d command count", i), ncmd, int'(VT[i].ncmd));
      chk($sformatf("R3 R4 R7 vec %0d command codes", i), int'(cmds), int'(VT[i].cmds));
      chk($sformatf("R4 R6 R7 vec %0d cache command", i), int'(gpu_seen), int'(VT[i].gpu));
      if (VT[i].op[1]) begin
        chk($sformatf("R2 vec %0d no access", i), nacc, 0);
      end else begin
        chk($sformatf("R3 vec %0d first write addr", i), int'(w0a), 2);
        chk($sformatf("R3 vec %0d low half", i), int'(w0d), int'(lw[31:0]));
        chk($sformatf("R3 vec %0d second write addr", i), int'(w1a), 3);
        chk($sformatf("R3 vec %0d high half", i), int'(w1d), int'(lw[63:32]));
      end
      if (i == 3)
        chk("R5 retry spacing", int'(min_gap >= TD), 1);
    end

    // R8: request presented while busy is not taken
    run_op(VT[0], 64'h1234_5678_9ABC_DEF0, 1'b1);
    chk("R8 intrude err", got_err, 0);
    chk("R8 intrude commands", int'(cmds), 32'h0402);
    repeat (2) @(negedge clk);
    chk("R8 no late done", int'(done), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule